// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the home node for a small group of memory blocks in a system where several caches keep coherent copies. For every block it stores the memory word, a dirty flag and a presence vector with one bit for each cache. Caches send two kinds of request: a read miss, which asks for a shared copy, and a write intent, which asks for exclusive write permission. The controller answers each one on a single response channel. The response carries the data word and a flag that says whether writing is allowed.

A read miss to a dirty block first sends a recall to the one cache that owns the block. The owner gives up write permission and returns its updated word. The controller stores that word in memory, marks the block clean, keeps both the owner and the requester as sharers, and sends the word to the requester. A write intent sends one invalidate message to every other sharer. It names those sharers in a mask. The write grant is held back until each of them has returned an acknowledge. A cache that takes a write miss first issues a read miss and then a write intent. The write intent never recalls data.

The controller handles one transaction at a time. While a transaction is open, the request channel is held not-ready.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every block is clean, no cache holds a copy, and block b holds the word 0xA0+b. No response, recall or invalidate is pending, and the request channel is ready.
- R2: A read miss to a clean block gets a response in the cycle after it is accepted. The response carries the memory word and has the write-permission flag at 0. The requester's presence bit is added.
- R3: A read miss to a dirty block raises a recall in the cycle after acceptance, addressed to the only cache that has its presence bit set. No response is sent until the writeback is taken. The response then comes in the cycle after the writeback, carries the written-back word, and has the write-permission flag at 0. After this, memory holds that word, the block is clean, and the sharers are exactly the old owner and the requester.
- R4: A write intent to a block that has sharers other than the requester raises an invalidate in the cycle after acceptance. Its mask holds one bit per cache (bit i is cache i) and covers exactly those other sharers.
- R5: The write grant is withheld until every cache in the invalidate mask has acknowledged. The grant response appears two cycles after the clock edge that samples the last acknowledge. An acknowledge from a cache outside the mask has no effect.
- R6: A write grant has the write-permission flag at 1 and carries the memory word. Afterwards the block is dirty and its only sharer is the requester. When no other cache shares the block, the grant comes in the cycle after acceptance and no invalidate is sent.
- R7: The request channel is ready only when no transaction is open. It goes low from the edge that accepts a request until the edge that hands over that request's response.
- R8: While the response is valid and not taken, it stays valid and its data, destination and permission flag do not change.
- R9: A write miss, done as a read miss followed by a write intent, leaves the requester as the sole owner. The write intent invalidates the copy held by the block's former owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_src | input | CW | Requesting cache index |
| req_blk | input | BW | Target block index |
| req_wr | input | 1 | 1 = write intent, 0 = read miss |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_dst | output | CW | Cache receiving the response |
| rsp_blk | output | BW | Block of the response |
| rsp_data | output | DW | Block word |
| rsp_wr_ok | output | 1 | Write permission granted |
| rcl_valid | output | 1 | Recall to owner present |
| rcl_ready | input | 1 | Recall taken |
| rcl_dst | output | CW | Owner being recalled |
| rcl_blk | output | BW | Recalled block |
| wb_valid | input | 1 | Owner writeback present |
| wb_ready | output | 1 | Writeback accepted when high with wb_valid |
| wb_data | input | DW | Written-back word |
| inv_valid | output | 1 | Invalidate message present |
| inv_ready | input | 1 | Invalidate taken |
| inv_mask | output | N_CACHE | Caches to invalidate, bit i = cache i |
| inv_blk | output | BW | Block to invalidate |
| ack_in | input | N_CACHE | Per-cache invalidate acknowledge pulses |

## Verification
Each result has a fixed cycle in which it must appear, counted from the clock edge that caused it. A clean read response or a grant without sharers is due one cycle after acceptance, and the same one-cycle delay applies to a recall or an invalidate. A recall response is due one cycle after the writeback edge. A grant that follows invalidates is due two cycles after the edge that samples the last acknowledge. The bench drives inputs and samples outputs on the falling edge. It checks each output exactly in the cycle it is due, and checks that the output is still absent in every cycle before that. A behavioural model of the dirty flags, sharer masks and memory words sets the expected values. The ready signal is also compared with the model's busy state on every clock.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECALL,
    ST_WBACK,
    ST_INVAL,
    ST_ACKWAIT,
    ST_RESP
  } dir_state_e;

  // number of set bits in a vector of up to 32 caches
  function automatic logic [5:0] ones32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + 6'(v[i]);
    return n;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic logic [4:0] low_index(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
    return r;
  endfunction

  // reset contents of memory block b
  function automatic logic [31:0] mem_seed(input int unsigned b);
    return 32'hA0 + 32'(b);
  endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
  import coh_dir_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 4,
  parameter int DW      = 8,
  localparam int BW     = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BW-1:0]      rd_blk,
  output logic               rd_dirty,
  output logic [N_CACHE-1:0] rd_pres,
  output logic [DW-1:0]      rd_data,
  input  logic               wr_en,
  input  logic [BW-1:0]      wr_blk,
  input  logic               wr_dirty,
  input  logic [N_CACHE-1:0] wr_pres,
  input  logic               mem_we,
  input  logic [DW-1:0]      mem_wdata
);

  logic               dirty_q [N_BLK];
  logic [N_CACHE-1:0] pres_q  [N_BLK];
  logic [DW-1:0]      mem_q   [N_BLK];

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    wire hit_dir = wr_en  && (wr_blk == BW'(g));
    wire hit_mem = mem_we && (wr_blk == BW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty_q[g] <= 1'b0;
        pres_q[g]  <= '0;
        mem_q[g]   <= DW'(mem_seed(g));
      end else begin
        if (hit_dir) begin
          dirty_q[g] <= wr_dirty;
          pres_q[g]  <= wr_pres;
        end
        if (hit_mem) mem_q[g] <= mem_wdata;
      end
    end

    // a dirty block always has exactly one holder, the owner to recall
    p_owner_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> ($countones(pres_q[g]) == 1));
  end

  assign rd_dirty = dirty_q[rd_blk];
  assign rd_pres  = pres_q[rd_blk];
  assign rd_data  = mem_q[rd_blk];

endmodule

// File: rtl/ack_tracker.sv
module ack_tracker
  import coh_dir_pkg::*;
#(
  parameter int N_CACHE = 4,
  localparam int CNTW   = $clog2(N_CACHE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CACHE-1:0] load_mask,
  input  logic [N_CACHE-1:0] ack_in,
  output logic [N_CACHE-1:0] pend_mask,
  output logic [CNTW-1:0]    pend_cnt,
  output logic               all_acked
);

  logic [N_CACHE-1:0] pend_q;
  logic [CNTW-1:0]    cnt_q;
  logic [N_CACHE-1:0] hits;

  // only acknowledges from caches still owed count
  assign hits = ack_in & pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      pend_q <= load_mask;
      cnt_q  <= CNTW'(ones32(32'(load_mask)));
    end else begin
      pend_q <= pend_q & ~hits;
      cnt_q  <= cnt_q - CNTW'(ones32(32'(hits)));
    end
  end

  assign pend_mask = pend_q;
  assign pend_cnt  = cnt_q;
  assign all_acked = (cnt_q == '0);

  // counter and outstanding mask must agree at all times
  p_cnt_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt == CNTW'($countones(pend_mask)));

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_BLK   = 4,
  parameter int DW      = 8,
  localparam int CW     = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
  localparam int BW     = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int CNTW   = $clog2(N_CACHE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CW-1:0]      req_src,
  input  logic [BW-1:0]      req_blk,
  input  logic               req_wr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [CW-1:0]      rsp_dst,
  output logic [BW-1:0]      rsp_blk,
  output logic [DW-1:0]      rsp_data,
  output logic               rsp_wr_ok,
  output logic               rcl_valid,
  input  logic               rcl_ready,
  output logic [CW-1:0]      rcl_dst,
  output logic [BW-1:0]      rcl_blk,
  input  logic               wb_valid,
  output logic               wb_ready,
  input  logic [DW-1:0]      wb_data,
  output logic               inv_valid,
  input  logic               inv_ready,
  output logic [N_CACHE-1:0] inv_mask,
  output logic [BW-1:0]      inv_blk,
  input  logic [N_CACHE-1:0] ack_in
);

  dir_state_e         state_q, state_n;
  logic [CW-1:0]      src_q, owner_q;
  logic [BW-1:0]      blk_q;
  logic               wr_q;
  logic [N_CACHE-1:0] inv_mask_q;
  logic [DW-1:0]      rsp_data_q;
  logic               rsp_wr_q;

  // store interface
  logic [BW-1:0]      st_rd_blk;
  logic               st_dirty;
  logic [N_CACHE-1:0] st_pres;
  logic [DW-1:0]      st_data;
  logic               st_wr_en, st_wr_dirty, st_mem_we;
  logic [N_CACHE-1:0] st_wr_pres;

  // tracker interface
  logic               trk_load;
  logic [N_CACHE-1:0] trk_pend;
  logic [CNTW-1:0]    trk_cnt;
  logic               trk_done;

  // named events
  logic               accept, enter_rsp, grant_fire, wb_fire;
  logic [N_CACHE-1:0] req_bit, held_bit, owner_bit, others;

  assign accept     = req_valid && req_ready;
  assign req_bit    = N_CACHE'(1) << req_src;
  assign held_bit   = N_CACHE'(1) << src_q;
  assign owner_bit  = N_CACHE'(1) << owner_q;
  assign st_rd_blk  = (state_q == ST_IDLE) ? req_blk : blk_q;
  assign others     = st_pres & ~req_bit;
  assign grant_fire = (state_q == ST_ACKWAIT) && trk_done;
  assign wb_fire    = (state_q == ST_WBACK) && wb_valid;
  assign enter_rsp  = (state_n == ST_RESP) && (state_q != ST_RESP);

  dir_store #(.N_CACHE(N_CACHE), .N_BLK(N_BLK), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_blk    (st_rd_blk),
    .rd_dirty  (st_dirty),
    .rd_pres   (st_pres),
    .rd_data   (st_data),
    .wr_en     (st_wr_en),
    .wr_blk    (st_rd_blk),
    .wr_dirty  (st_wr_dirty),
    .wr_pres   (st_wr_pres),
    .mem_we    (st_mem_we),
    .mem_wdata (wb_data)
  );

  ack_tracker #(.N_CACHE(N_CACHE)) u_acks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (trk_load),
    .load_mask (others),
    .ack_in    (ack_in),
    .pend_mask (trk_pend),
    .pend_cnt  (trk_cnt),
    .all_acked (trk_done)
  );

  always_comb begin
    state_n     = state_q;
    st_wr_en    = 1'b0;
    st_wr_dirty = st_dirty;
    st_wr_pres  = st_pres;
    st_mem_we   = 1'b0;
    trk_load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_wr) begin
          if (st_dirty) state_n = ST_RECALL;
          else begin
            st_wr_en   = 1'b1;
            st_wr_pres = st_pres | req_bit;
            state_n    = ST_RESP;
          end
        end else if (others != '0) begin
          trk_load = 1'b1;
          state_n  = ST_INVAL;
        end else begin
          st_wr_en    = 1'b1;
          st_wr_dirty = 1'b1;
          st_wr_pres  = req_bit;
          state_n     = ST_RESP;
        end
      end
      ST_RECALL: if (rcl_ready) state_n = ST_WBACK;
      ST_WBACK: if (wb_fire) begin
        st_wr_en    = 1'b1;
        st_wr_dirty = 1'b0;
        st_wr_pres  = owner_bit | held_bit;
        st_mem_we   = 1'b1;
        state_n     = ST_RESP;
      end
      ST_INVAL: if (inv_ready) state_n = ST_ACKWAIT;
      ST_ACKWAIT: if (grant_fire) begin
        st_wr_en    = 1'b1;
        st_wr_dirty = 1'b1;
        st_wr_pres  = held_bit;
        state_n     = ST_RESP;
      end
      ST_RESP: if (rsp_ready) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      src_q      <= '0;
      blk_q      <= '0;
      wr_q       <= 1'b0;
      owner_q    <= '0;
      inv_mask_q <= '0;
      rsp_data_q <= '0;
      rsp_wr_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        src_q      <= req_src;
        blk_q      <= req_blk;
        wr_q       <= req_wr;
        owner_q    <= CW'(low_index(32'(st_pres)));
        inv_mask_q <= others;
      end
      if (enter_rsp) begin
        rsp_data_q <= wb_fire ? wb_data : st_data;
        rsp_wr_q   <= st_wr_dirty;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_dst   = src_q;
  assign rsp_blk   = blk_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_wr_ok = rsp_wr_q;
  assign rcl_valid = (state_q == ST_RECALL);
  assign rcl_dst   = owner_q;
  assign rcl_blk   = blk_q;
  assign wb_ready  = (state_q == ST_WBACK);
  assign inv_valid = (state_q == ST_INVAL);
  assign inv_mask  = inv_mask_q;
  assign inv_blk   = blk_q;

  // R7: an open channel means nothing else is in flight
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(rsp_valid || rcl_valid || inv_valid || wb_ready));

  // R8: a pending response does not move
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                   && $stable(rsp_wr_ok) && $stable(rsp_dst)));

  // R4: invalidates never target the requester and never go out empty
  p_inv_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ((inv_mask != '0) && !inv_mask[src_q]));

  // R5: a grant only leaves once the tracker owes nothing
  p_grant_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> ((trk_cnt == '0) && (trk_pend == '0)));

  // R2: read responses never carry write permission
  p_read_no_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !wr_q) |-> !rsp_wr_ok);

  // R6: at grant the block is dirty and held by the requester alone
  p_grant_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> (st_dirty && (st_pres == held_bit)));

endmodule

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;
  localparam int NC = 4;
  localparam int NB = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_wr = 0;
  logic [1:0]    req_src = 0, req_blk = 0;
  logic          req_ready;
  logic          rsp_valid, rsp_wr_ok;
  logic          rsp_ready = 1;
  logic [1:0]    rsp_dst, rsp_blk, rcl_dst, rcl_blk, inv_blk;
  logic [DW-1:0] rsp_data;
  logic          rcl_valid, wb_ready, inv_valid;
  logic          rcl_ready = 1, inv_ready = 1, wb_valid = 0;
  logic [DW-1:0] wb_data = 0;
  logic [NC-1:0] inv_mask;
  logic [NC-1:0] ack_in = 0;

  coh_dir_ctrl #(.N_CACHE(NC), .N_BLK(NB), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_blk(req_blk), .req_wr(req_wr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dst(rsp_dst),
    .rsp_blk(rsp_blk), .rsp_data(rsp_data), .rsp_wr_ok(rsp_wr_ok),
    .rcl_valid(rcl_valid), .rcl_ready(rcl_ready), .rcl_dst(rcl_dst),
    .rcl_blk(rcl_blk),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_mask(inv_mask),
    .inv_blk(inv_blk), .ack_in(ack_in)
  );

  int checks = 0, fails = 0;
  bit busy = 0, done = 0;

  // behavioural reference state
  bit m_dirty[NB];
  int m_pres[NB];
  int m_mem[NB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R7: per-clock comparison of ready against the model's busy flag
  always @(negedge clk)
    if (rst_n && !done) chk(req_ready == !busy, "R7 ready vs busy", req_ready, !busy);

  function automatic int owner_of(input int mask);
    for (int i = 0; i < NC; i++) if (mask[i]) return i;
    return -1;
  endfunction

  task automatic issue(input int src, input int blk, input bit wr);
    @(negedge clk);
    req_valid = 1; req_src = 2'(src); req_blk = 2'(blk); req_wr = wr;
    @(posedge clk);
    busy = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_rsp();
    @(posedge clk);
    busy = 0;
  endtask

  task automatic clean_read(input int src, input int blk, input string tag);
    int exp;
    exp = m_mem[blk];
    issue(src, blk, 0);
    chk(rsp_valid == 1, {tag, " read response due"}, rsp_valid, 1);
    chk(rsp_data == DW'(exp), {tag, " read data"}, rsp_data, exp);
    chk(rsp_wr_ok == 0, {tag, " read has no write permission"}, rsp_wr_ok, 0);
    chk(rsp_dst == 2'(src), {tag, " read destination"}, rsp_dst, src);
    finish_rsp();
    m_pres[blk] |= (1 << src);
  endtask

  task automatic dirty_read(input int src, input int blk, input int wb, input bit hold);
    int own;
    own = owner_of(m_pres[blk]);
    issue(src, blk, 0);
    chk(rcl_valid == 1, "R3 recall due", rcl_valid, 1);
    chk(rcl_dst == 2'(own), "R3 recall to owner", rcl_dst, own);
    chk(rsp_valid == 0, "R3 no early response", rsp_valid, 0);
    @(negedge clk);
    chk(rcl_valid == 0, "R3 recall taken", rcl_valid, 0);
    for (int k = 0; k < 2; k++) begin
      chk(rsp_valid == 0, "R3 waits for writeback", rsp_valid, 0);
      @(negedge clk);
    end
    wb_valid = 1; wb_data = DW'(wb);
    if (hold) rsp_ready = 0;
    @(negedge clk);
    wb_valid = 0;
    chk(rsp_valid == 1, "R3 response after writeback", rsp_valid, 1);
    chk(rsp_data == DW'(wb), "R3 forwarded data", rsp_data, wb);
    chk(rsp_wr_ok == 0, "R3 shared copy only", rsp_wr_ok, 0);
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(rsp_valid == 1, "R8 held valid", rsp_valid, 1);
        chk(rsp_data == DW'(wb), "R8 held data", rsp_data, wb);
        chk(rsp_dst == 2'(src), "R8 held destination", rsp_dst, src);
      end
      rsp_ready = 1;
    end
    finish_rsp();
    m_mem[blk] = wb;
    m_dirty[blk] = 0;
    m_pres[blk] = (1 << own) | (1 << src);
  endtask

  task automatic write_intent(input int src, input int blk, input int stray, input string tag);
    int others;
    int left;
    others = m_pres[blk] & ~(1 << src);
    issue(src, blk, 1);
    if (others == 0) begin
      chk(inv_valid == 0, "R6 no invalidate without sharers", inv_valid, 0);
      chk(rsp_valid == 1, "R6 immediate grant", rsp_valid, 1);
    end else begin
      chk(inv_valid == 1, {tag, " invalidate due"}, inv_valid, 1);
      chk(int'(inv_mask) == others, {tag, " invalidate mask"}, inv_mask, others);
      chk(rsp_valid == 0, "R5 no grant before acks", rsp_valid, 0);
      @(negedge clk);
      if (stray >= 0) begin
        ack_in = NC'(1 << stray);
        @(negedge clk);
        ack_in = 0;
        chk(rsp_valid == 0, "R5 stray ack ignored", rsp_valid, 0);
        @(negedge clk);
      end
      left = $countones(others);
      for (int i = 0; i < NC; i++) begin
        if (others[i]) begin
          ack_in = NC'(1 << i);
          @(negedge clk);
          ack_in = 0;
          left--;
          chk(rsp_valid == 0, "R5 grant withheld", rsp_valid, 0);
          @(negedge clk);
          if (left > 0) chk(rsp_valid == 0, "R5 grant withheld", rsp_valid, 0);
          else chk(rsp_valid == 1, "R5 grant two cycles after last ack", rsp_valid, 1);
        end
      end
    end
    chk(rsp_wr_ok == 1, "R6 write permission", rsp_wr_ok, 1);
    chk(rsp_data == DW'(m_mem[blk]), "R6 grant data", rsp_data, m_mem[blk]);
    chk(rsp_dst == 2'(src), "R6 grant destination", rsp_dst, src);
    finish_rsp();
    m_dirty[blk] = 1;
    m_pres[blk] = (1 << src);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_dirty[b] = 0; m_pres[b] = 0; m_mem[b] = (160 + b) & 255;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1 no response", rsp_valid, 0);
    chk(rcl_valid == 0, "R1 no recall", rcl_valid, 0);
    chk(inv_valid == 0, "R1 no invalidate", inv_valid, 0);
    for (int b = 0; b < NB; b++) clean_read(0, b, "R1");
    clean_read(1, 0, "R2");
    clean_read(2, 0, "R2");
    write_intent(1, 0, 3, "R4");     // sharers 0 and 2, stray ack from 3
    dirty_read(3, 0, 8'h5C, 0);      // R9 write miss step one: recall from 1
    write_intent(3, 0, -1, "R9");    // R9 step two: invalidate former owner 1
    dirty_read(2, 0, 8'h77, 1);      // recall from 3 with held response
    clean_read(0, 0, "R3 memory updated");
    write_intent(0, 2, -1, "R6");    // sole sharer, immediate grant
    dirty_read(1, 2, 8'h31, 0);      // R6: recall goes to the granted owner 0
    write_intent(2, 1, -1, "R4");
    write_intent(3, 3, -1, "R4");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule